// File: doc/BRIEF.md
# Variable Pulse Width Bus Symbol Receiver

This block watches a single-wire serial bus whose symbols are coded by pulse width, and turns it into decoded events. It measures how long the bus held each level between two edges, counting ticks of a 1 µs timebase, and sorts each interval by its length and level. The possible results are a data bit, a start-of-frame, an end-of-frame, a break, an invalid symbol, or a glitch that is dropped. Data bits alternate between the active and passive levels, so every bit carries exactly one edge. A bit's value depends on two things: whether its interval was short or long, and the level the bus held during it.

The receiver is a five-state machine. **ST_SEEK** waits for an idle gap after reset, after a frame ends, after an error or after a break. **ST_IDLE** means the bus is idle and any node may transmit. **ST_SOF** times a candidate start pulse. **ST_DATA** decodes bits. **ST_BREAK** holds while an over-long active pulse lasts. The transitions are these:
- SEEK→IDLE, called *ifs_done*: the bus is passive for a full inter-frame space.
- IDLE→SOF, called *rise*: any edge.
- SOF→DATA, called *sof_ok*: a start-length pulse ends.
- SOF→IDLE, called *sof_glitch*.
- SOF→SEEK, called *sof_bad*.
- DATA→SEEK, called *eof*, *bad_symbol* or *break_in_frame*.
- Any measuring state→BREAK, called *break*.
- BREAK→SEEK, called *release*.

An optional fast mode scales every limit down by four and counts a tick that runs four times faster. A break clears fast mode by itself.

Top module: `vpw_symbol_rx`

## Requirements
- R1: While reset is asserted, every event output is low, `idle_bus` is low and `fast_mode` is low.
- R2: `idle_bus` rises only after the bus has been passive for 300 ticks since the last edge (75 fast ticks in fast mode). It stays low before that. No bit, frame-end or invalid event is output while it is high.
- R3: From idle, an active pulse of 163 to 239 ticks produces one `frame_start` pulse and starts bit decoding. At most one of `bit_valid`, `frame_start`, `frame_end` and `break_det` is high in any cycle.
- R4: Inside a frame, an interval of 34 to 95 ticks is a short bit and one of 96 to 162 ticks is a long bit. Each gives a one-cycle `bit_valid`. The value on `bit_value` is 1 for passive-short or active-long, and 0 for passive-long or active-short.
- R5: Inside a frame, a passive level that reaches 163 ticks gives one `frame_end` pulse.
- R6: An interval shorter than 34 ticks gives no event. From idle, such a pulse returns the block to idle. Inside a frame, it is skipped.
- R7: An interval in no valid range gives a one-cycle `invalid_sym` pulse. After it, no events are output until the next idle gap. Two cases count: a pulse from idle of 34 to 162 ticks, and an active interval in a frame of 163 ticks or more that ends before the break limit.
- R8: An active level lasting 240 ticks or more gives exactly one `break_det` pulse.
- R9: A break inside a frame also gives `invalid_sym`, and the frame is dropped: no `frame_end` follows.
- R10: `tx_error` pulses together with `break_det` when `tx_active` is high, and never at any other time.
- R11: `fast_set` sets `fast_mode` and `fast_clr` clears it. While `fast_mode` is high, timing uses `tick_4x`, and every limit is the normal one divided by four (8, 24, 40, 59 and 75 ticks).
- R12: A break clears `fast_mode` in the cycle it is reported, ahead of a `fast_set` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1x | input | 1 | One-cycle pulse every 1 µs |
| tick_4x | input | 1 | One-cycle pulse every 0.25 µs |
| bus_in | input | 1 | Raw bus level, 1 = active |
| tx_active | input | 1 | Local node is transmitting |
| fast_set | input | 1 | Enable fast mode |
| fast_clr | input | 1 | Disable fast mode |
| bit_valid | output | 1 | Decoded bit strobe |
| bit_value | output | 1 | Decoded bit value |
| frame_start | output | 1 | Start-of-frame pulse |
| frame_end | output | 1 | End-of-frame pulse |
| idle_bus | output | 1 | Bus idle flag |
| break_det | output | 1 | Break detected pulse |
| invalid_sym | output | 1 | Invalid symbol pulse |
| tx_error | output | 1 | Break while transmitting |
| fast_mode | output | 1 | Fast mode enabled |

## Verification
Most wrong internal states show up at the ports within one interval. A wrong state or classification changes the pulse counts and bit values seen when the next edge arrives, or when the next limit is crossed (at most 300 ticks later). A state stuck outside ST_SEEK shows up as `idle_bus` failing to rise one inter-frame space after the last edge. Sweeping the pulse width tick by tick in fast mode puts a trial on each side of every limit, so an off-by-one in any threshold changes a count in the neighbouring trial.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;

    typedef enum logic [2:0] {
        ST_SEEK,
        ST_IDLE,
        ST_SOF,
        ST_DATA,
        ST_BREAK
    } rx_state_e;

    typedef enum logic [2:0] {
        CL_GLITCH,
        CL_SHORT,
        CL_LONG,
        CL_DELIM,
        CL_OVER
    } span_class_e;

    // Interval limits in ticks
    typedef struct packed {
        logic [15:0] glitch;     // below: noise
        logic [15:0] split;      // below: short bit, at or above: long bit
        logic [15:0] long_end;   // below: long bit, at or above: delimiter
        logic [15:0] delim_end;  // last delimiter length
        logic [15:0] ifs;        // passive length that makes the bus idle
    } limits_t;

    function automatic limits_t scale_limits(limits_t b, int div);
        limits_t r;
        r.glitch    = 16'(int'(b.glitch) / div);
        r.split     = 16'(int'(b.split) / div);
        r.long_end  = 16'(int'(b.long_end) / div);
        r.delim_end = 16'(int'(b.delim_end) / div);
        r.ifs       = 16'(int'(b.ifs) / div);
        return r;
    endfunction

endpackage

// File: rtl/vpw_edge_sync.sv
module vpw_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_in,
    output logic level,
    output logic bus_edge
);
    logic [STAGES-1:0] chain;
    logic              level_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= bus_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= chain[STAGES-1];
    end

    assign level    = level_q;
    assign bus_edge = chain[STAGES-1] ^ level_q;
endmodule

// File: rtl/vpw_span_timer.sv
module vpw_span_timer #(
    parameter int CW  = 9,
    parameter int SAT = 300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_1x,
    input  logic          tick_4x,
    input  logic          fast,
    input  logic          bus_edge,
    output logic          tick,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] SAT_V = CW'(SAT);

    assign tick = fast ? tick_4x : tick_1x;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       count <= '0;
        else if (bus_edge)                count <= '0;
        else if (tick && count != SAT_V)  count <= count + 1'b1;
    end
endmodule

// File: rtl/vpw_span_classifier.sv
module vpw_span_classifier
    import vpw_rx_pkg::*;
#(
    parameter int CW           = 9,
    parameter int GLITCH_US    = 34,
    parameter int SPLIT_US     = 96,
    parameter int LONG_END_US  = 163,
    parameter int DELIM_END_US = 239,
    parameter int IFS_US       = 300,
    parameter int FAST_DIV     = 4
) (
    input  logic          fast,
    input  logic          tick,
    input  logic [CW-1:0] count,
    output span_class_e   cls,
    output logic          eof_hit,
    output logic          brk_hit,
    output logic          ifs_hit
);
    localparam limits_t BASE_LIM = '{
        glitch:    16'(GLITCH_US),
        split:     16'(SPLIT_US),
        long_end:  16'(LONG_END_US),
        delim_end: 16'(DELIM_END_US),
        ifs:       16'(IFS_US)
    };
    localparam limits_t FAST_LIM = scale_limits(BASE_LIM, FAST_DIV);

    limits_t     lim;
    logic [15:0] dur;

    assign lim = fast ? FAST_LIM : BASE_LIM;
    assign dur = 16'(count) + 16'(tick);

    always_comb begin
        if (dur < lim.glitch)          cls = CL_GLITCH;
        else if (dur < lim.split)      cls = CL_SHORT;
        else if (dur < lim.long_end)   cls = CL_LONG;
        else if (dur <= lim.delim_end) cls = CL_DELIM;
        else                           cls = CL_OVER;
    end

    // Limit crossings while a level is still held
    assign eof_hit = tick && (dur == lim.long_end);
    assign brk_hit = tick && (dur == lim.delim_end + 16'd1);
    assign ifs_hit = tick && (dur == lim.ifs);
endmodule

// File: rtl/vpw_symbol_rx.sv
module vpw_symbol_rx
    import vpw_rx_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int GLITCH_US    = 34,
    parameter int SPLIT_US     = 96,
    parameter int LONG_END_US  = 163,
    parameter int DELIM_END_US = 239,
    parameter int IFS_US       = 300,
    parameter int FAST_DIV     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_1x,
    input  logic tick_4x,
    input  logic bus_in,
    input  logic tx_active,
    input  logic fast_set,
    input  logic fast_clr,
    output logic bit_valid,
    output logic bit_value,
    output logic frame_start,
    output logic frame_end,
    output logic idle_bus,
    output logic break_det,
    output logic invalid_sym,
    output logic tx_error,
    output logic fast_mode
);
    localparam int CW = $clog2(IFS_US + 1);

    rx_state_e     st, nxt;
    span_class_e   cls;
    logic          level, bus_edge, tick;
    logic [CW-1:0] count;
    logic          eof_hit, brk_hit, ifs_hit;
    logic          fast_q;
    logic          n_bitv, n_bitval, n_sof, n_eof, n_brk, n_inv;

    vpw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_in   (bus_in),
        .level    (level),
        .bus_edge (bus_edge)
    );

    vpw_span_timer #(.CW(CW), .SAT(IFS_US)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_1x  (tick_1x),
        .tick_4x  (tick_4x),
        .fast     (fast_q),
        .bus_edge (bus_edge),
        .tick     (tick),
        .count    (count)
    );

    vpw_span_classifier #(
        .CW(CW), .GLITCH_US(GLITCH_US), .SPLIT_US(SPLIT_US),
        .LONG_END_US(LONG_END_US), .DELIM_END_US(DELIM_END_US),
        .IFS_US(IFS_US), .FAST_DIV(FAST_DIV)
    ) u_class (
        .fast    (fast_q),
        .tick    (tick),
        .count   (count),
        .cls     (cls),
        .eof_hit (eof_hit),
        .brk_hit (brk_hit),
        .ifs_hit (ifs_hit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_SEEK;
        else        st <= nxt;
    end

    // Next state and event decode
    always_comb begin
        nxt      = st;
        n_bitv   = 1'b0;
        n_bitval = 1'b0;
        n_sof    = 1'b0;
        n_eof    = 1'b0;
        n_brk    = 1'b0;
        n_inv    = 1'b0;
        unique case (st)
            ST_SEEK: begin
                if (!level && ifs_hit) begin
                    nxt = bus_edge ? ST_SOF : ST_IDLE;          // ifs_done
                end else if (level && brk_hit) begin
                    n_brk = 1'b1;
                    nxt   = bus_edge ? ST_SEEK : ST_BREAK;      // break
                end
            end
            ST_IDLE: begin
                if (bus_edge) nxt = ST_SOF;                     // rise
            end
            ST_SOF: begin
                if (brk_hit) begin
                    n_brk = 1'b1;
                    nxt   = bus_edge ? ST_SEEK : ST_BREAK;      // break
                end else if (bus_edge) begin
                    unique case (cls)
                        CL_GLITCH: nxt = ST_IDLE;               // sof_glitch
                        CL_DELIM: begin
                            n_sof = 1'b1;
                            nxt   = ST_DATA;                    // sof_ok
                        end
                        default: begin
                            n_inv = 1'b1;
                            nxt   = ST_SEEK;                    // sof_bad
                        end
                    endcase
                end
            end
            ST_DATA: begin
                if (level && brk_hit) begin
                    n_brk = 1'b1;
                    n_inv = 1'b1;
                    nxt   = bus_edge ? ST_SEEK : ST_BREAK;      // break_in_frame
                end else if (!level && eof_hit) begin
                    n_eof = 1'b1;
                    nxt   = ST_SEEK;                            // eof
                end else if (bus_edge) begin
                    unique case (cls)
                        CL_GLITCH: nxt = ST_DATA;
                        CL_SHORT: begin
                            n_bitv   = 1'b1;
                            n_bitval = ~level;
                        end
                        CL_LONG: begin
                            n_bitv   = 1'b1;
                            n_bitval = level;
                        end
                        default: begin
                            n_inv = 1'b1;
                            nxt   = ST_SEEK;                    // bad_symbol
                        end
                    endcase
                end
            end
            ST_BREAK: begin
                if (bus_edge) nxt = ST_SEEK;                    // release
            end
            default: nxt = ST_SEEK;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_valid   <= 1'b0;
            bit_value   <= 1'b0;
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
            idle_bus    <= 1'b0;
            break_det   <= 1'b0;
            invalid_sym <= 1'b0;
            tx_error    <= 1'b0;
            fast_q      <= 1'b0;
        end else begin
            bit_valid   <= n_bitv;
            bit_value   <= n_bitval;
            frame_start <= n_sof;
            frame_end   <= n_eof;
            idle_bus    <= (nxt == ST_IDLE);
            break_det   <= n_brk;
            invalid_sym <= n_inv;
            tx_error    <= n_brk & tx_active;
            if (n_brk)         fast_q <= 1'b0;
            else if (fast_set) fast_q <= 1'b1;
            else if (fast_clr) fast_q <= 1'b0;
        end
    end

    assign fast_mode = fast_q;
endmodule

// File: rtl/vpw_symbol_rx_checker.sv
module vpw_symbol_rx_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_valid,
    input logic frame_start,
    input logic frame_end,
    input logic idle_bus,
    input logic break_det,
    input logic invalid_sym,
    input logic tx_error,
    input logic fast_mode
);
    p_one_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_valid, frame_start, frame_end, break_det}));

    p_eof_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    p_idle_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idle_bus |-> !(bit_valid || frame_end || invalid_sym));

    p_break_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        break_det |=> !break_det);

    p_txerr_with_break_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_error |-> break_det);

    p_break_clears_fast_r12: assert property (@(posedge clk) disable iff (!rst_n)
        break_det |-> !fast_mode);
endmodule

bind vpw_symbol_rx vpw_symbol_rx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_valid   (bit_valid),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .idle_bus    (idle_bus),
    .break_det   (break_det),
    .invalid_sym (invalid_sym),
    .tx_error    (tx_error),
    .fast_mode   (fast_mode)
);

// File: tb/vpw_symbol_rx_test.sv
module vpw_symbol_rx_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1x, tick_4x;
    logic bus_in = 1'b0, tx_active = 1'b0, fast_set = 1'b0, fast_clr = 1'b0;
    logic bit_valid, bit_value, frame_start, frame_end, idle_bus;
    logic break_det, invalid_sym, tx_error, fast_mode;
    logic [1:0] tdiv = 2'd0;

    int total = 0, fails = 0, cyc = 0;
    int n_sof = 0, n_eof = 0, n_brk = 0, n_inv = 0, n_txe = 0, n_bits = 0;
    logic [31:0] bitsr = '0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) tdiv <= tdiv + 2'd1;
    assign tick_1x = (tdiv == 2'd0);
    assign tick_4x = 1'b1;

    vpw_symbol_rx uut (
        .clk(clk), .rst_n(rst_n), .tick_1x(tick_1x), .tick_4x(tick_4x),
        .bus_in(bus_in), .tx_active(tx_active), .fast_set(fast_set), .fast_clr(fast_clr),
        .bit_valid(bit_valid), .bit_value(bit_value), .frame_start(frame_start),
        .frame_end(frame_end), .idle_bus(idle_bus), .break_det(break_det),
        .invalid_sym(invalid_sym), .tx_error(tx_error), .fast_mode(fast_mode)
    );

    // Event monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_start) n_sof++;
            if (frame_end)   n_eof++;
            if (break_det)   n_brk++;
            if (invalid_sym) n_inv++;
            if (tx_error)    n_txe++;
            if (bit_valid) begin
                n_bits++;
                bitsr = {bitsr[30:0], bit_value};
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            summary();
        end
    end

    task automatic check(string req, int act, int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        n_sof = 0; n_eof = 0; n_brk = 0; n_inv = 0; n_txe = 0; n_bits = 0; bitsr = '0;
    endtask

    task automatic hold(input logic lv, input int cycles);
        bus_in = lv;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic hold_us(input logic lv, input int us);
        hold(lv, 4 * us);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && !idle_bus; i++) @(negedge clk);
    endtask

    task automatic pulse_fast(input bit set);
        if (set) fast_set = 1'b1; else fast_clr = 1'b1;
        @(negedge clk);
        fast_set = 1'b0;
        fast_clr = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 outputs in reset", int'({bit_valid, frame_start, frame_end, break_det,
                                          invalid_sym, tx_error}), 0);
        check("R1 idle in reset", int'(idle_bus), 0);
        check("R1 fast in reset", int'(fast_mode), 0);
        rst_n = 1'b1;

        // R2: idle only after 300 passive ticks
        repeat (1100) @(negedge clk);
        check("R2 idle low at 275us", int'(idle_bus), 0);
        repeat (200) @(negedge clk);
        check("R2 idle high at 325us", int'(idle_bus), 1);

        // R6: glitch from idle
        clr_mon();
        hold_us(1'b1, 20);
        hold(1'b0, 20);
        check("R6 glitch no sof", n_sof, 0);
        check("R6 glitch no invalid", n_inv, 0);
        check("R6 glitch back to idle", int'(idle_bus), 1);

        // R3 R4 R5: full frame, normal timing
        begin
            logic [15:0] pat = 16'hA5C3;
            logic lv = 1'b0;
            wait_idle();
            clr_mon();
            hold_us(1'b1, 200);
            for (int i = 15; i >= 0; i--) begin
                hold_us(lv, ((pat[i] ^ lv) != 1'b0) ? 64 : 128);
                lv = ~lv;
            end
            hold_us(1'b0, 290);
            check("R3 frame_start count", n_sof, 1);
            check("R4 bit count", n_bits, 16);
            check("R4 bit pattern", int'(bitsr[15:0]), int'(pat));
            check("R5 frame_end count", n_eof, 1);
            check("R7 no invalid in good frame", n_inv, 0);
            check("R2 idle low before ifs", int'(idle_bus), 0);
            hold_us(1'b0, 20);
            check("R2 idle high after ifs", int'(idle_bus), 1);
        end

        // R8 R9 R10: break inside frame, with and without transmit
        for (int tx = 1; tx >= 0; tx--) begin
            wait_idle();
            clr_mon();
            tx_active = (tx != 0);
            hold_us(1'b1, 200);
            hold_us(1'b0, 64);   // 1
            hold_us(1'b1, 64);   // 0
            hold_us(1'b0, 128);  // 0
            hold_us(1'b1, 300);  // break
            hold_us(1'b0, 400);
            tx_active = 1'b0;
            check("R4 bits before break", n_bits, 3);
            check("R4 bits value before break", int'(bitsr[2:0]), 3'b100);
            check("R8 single break", n_brk, 1);
            check("R9 break in frame invalid", n_inv, 1);
            check("R9 frame dropped", n_eof, 0);
            check("R10 tx_error follows tx_active", n_txe, tx);
        end

        // R7: over-long active symbol inside frame
        wait_idle();
        clr_mon();
        hold_us(1'b1, 200);
        hold_us(1'b0, 64);
        hold_us(1'b1, 200);
        hold_us(1'b0, 64);
        hold_us(1'b1, 64);
        hold_us(1'b0, 400);
        check("R7 bad active in frame", n_inv, 1);
        check("R7 ignored until idle", n_bits, 1);
        check("R7 no eof after error", n_eof, 0);

        // R7: start pulse too short but not a glitch
        wait_idle();
        clr_mon();
        hold_us(1'b1, 100);
        hold_us(1'b0, 50);
        check("R7 short start invalid", n_inv, 1);
        check("R7 short start no sof", n_sof, 0);
        check("R2 idle low after invalid", int'(idle_bus), 0);

        // R11: mode set and clear
        wait_idle();
        pulse_fast(1'b1);
        check("R11 fast set", int'(fast_mode), 1);
        pulse_fast(1'b0);
        check("R11 fast clear", int'(fast_mode), 0);

        // R2 R11: fast idle gap
        pulse_fast(1'b1);
        hold(1'b1, 20);
        hold(1'b0, 70);
        check("R2 fast idle low at 70", int'(idle_bus), 0);
        hold(1'b0, 15);
        check("R2 fast idle high at 85", int'(idle_bus), 1);

        // Start pulse sweep in fast mode: R3 R6 R7 R8 R11 R12
        for (int j = 1; j <= 70; j++) begin
            int e_sof, e_inv, e_brk;
            wait_idle();
            pulse_fast(1'b1);
            clr_mon();
            hold(1'b1, j);
            hold(1'b0, 100);
            e_sof = (j >= 40 && j <= 59) ? 1 : 0;
            e_inv = (j >= 8 && j <= 39) ? 1 : 0;
            e_brk = (j >= 60) ? 1 : 0;
            check($sformatf("R3 R11 sweep sof j=%0d", j), n_sof, e_sof);
            check($sformatf("R5 sweep eof j=%0d", j), n_eof, e_sof);
            check($sformatf("R6 R7 sweep invalid j=%0d", j), n_inv, e_inv);
            check($sformatf("R8 sweep break j=%0d", j), n_brk, e_brk);
            check($sformatf("R12 sweep fast j=%0d", j), int'(fast_mode), 1 - e_brk);
        end

        // Bit interval sweep in fast mode: R4 R5 R6 R11
        for (int k = 1; k <= 60; k++) begin
            int e_n, e_v;
            wait_idle();
            pulse_fast(1'b1);
            clr_mon();
            hold(1'b1, 50);
            hold(1'b0, k);
            hold(1'b1, 12);
            hold(1'b0, 100);
            if (k < 8)       begin e_n = 1; e_v = 0;     end
            else if (k < 24) begin e_n = 2; e_v = 2'b10; end
            else if (k < 40) begin e_n = 2; e_v = 2'b00; end
            else             begin e_n = 0; e_v = 0;     end
            check($sformatf("R4 R6 sweep bits k=%0d", k), n_bits, e_n);
            check($sformatf("R4 R11 sweep value k=%0d", k), int'(bitsr[1:0]) & ((1 << e_n) - 1), e_v);
            check($sformatf("R5 sweep eof k=%0d", k), n_eof, 1);
            check($sformatf("R7 sweep no invalid k=%0d", k), n_inv, 0);
        end

        done = 1'b1;
        summary();
    end
endmodule